// File: doc/BRIEF.md
# 64-bit Status and Configuration Register Bank

This block holds the software-visible registers of a data acquisition design. It has two spaces of 64-bit words, each with 128 entries. The status space is read-only and shows live values from surrounding logic, a calibration-done flag and two fixed identification words. The configuration space is read/write and drives its stored values onto a wide output bus for the rest of the chip. A bus bridge in front of the block turns host accesses into single-cycle read and write strobes.

A write is accepted only when all eight byte strobes are set, so narrower host accesses, such as 32-bit stores, change nothing. Configuration registers store only their low `CFG_BITS` bits. One configuration index is a command register and holds no value. A full write to it with data bit 0 set produces a one-cycle pulse, for example a soft reset. Software never has to clear it.

Top module: `regbank64`

## Requirements
- R1: Address bit 7 selects the space: 0 is status and 1 is configuration. Bits 6:0 give the index. A write to the status space changes no register and produces no pulse.
- R2: `rd_en` is sampled at a clock edge. `rdata` holds the selected word and `rd_valid` is 1 in the following cycle. `rd_valid` is 0 after any edge where `rd_en` was 0.
- R3: A configuration write with `wstrb` equal to 8'hFF stores the data. A later read of that index returns it.
- R4: A write with any `wstrb` bit at 0 is dropped. It changes no register and produces no pulse, including at the command index.
- R5: Write data bits at and above `CFG_BITS` (default 48) are ignored. They read back as 0.
- R6: Configuration index `CMD_IDX` (default 127) holds no value and always reads 0. A full-strobe write to it with `wdata[0]` = 1 raises `cmd_pulse` for exactly the next cycle. With `wdata[0]` = 0 the write gives no pulse.
- R7: Status index 111 reads `{63'b0, calib_done}`, sampled at the read edge.
- R8: Status index 124 reads the `BUILD_STAMP` parameter. Status index 126 reads the `MODULE_ID` parameter.
- R9: A status index below `N_STAT_IN` (default 16) reads word k of `stat_in`, which is bits k*64 and up. Every other status index reads 0.
- R10: While `rst_n` is low, all configuration registers, `rdata`, `rd_valid` and `cmd_pulse` are 0.
- R11: `cfg_q` carries configuration register i in bits i*`CFG_BITS` and up. It updates on the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 8 | Space bit and index |
| wdata | input | 64 | Write data |
| wstrb | input | 8 | Byte strobes; all must be set for a write |
| rdata | output | 64 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| stat_in | input | N_STAT_IN*64 | Live status words |
| calib_done | input | 1 | Memory calibration finished |
| cfg_q | output | 128*CFG_BITS | Configuration register contents |
| cmd_pulse | output | 1 | Self-clearing command pulse |

## Verification
The hardest case to reach from the ports is a write that looks complete but is not: a partial-strobe access to the command index or to a stored register. Such a write must leave no trace, either in the pulse output or in the stored word. The bench sweeps all 255 partial strobe patterns against one stored register and against the command index. Each sweep uses data that differs from what is held. After every access the bench reads the register back and checks `cmd_pulse`. It also writes every configuration index with a distinct pattern that sets the upper bits, then reads back all 256 addresses.

// File: rtl/regbank64_pkg.sv
package regbank64_pkg;
  typedef enum logic {
    SPACE_STATUS = 1'b0,
    SPACE_CONFIG = 1'b1
  } space_e;

  localparam int DEF_CALIB_IDX = 111;
  localparam int DEF_STAMP_IDX = 124;
  localparam int DEF_ID_IDX    = 126;
  localparam int DEF_CMD_IDX   = 127;
endpackage

// File: rtl/regbank64_wgate.sv
module regbank64_wgate
  import regbank64_pkg::*;
#(
  parameter int STRB_W = 8
) (
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wstrb,
  input  space_e            space,
  output logic              wr_full
);
  assign wr_full = wr_en && (&wstrb) && (space == SPACE_CONFIG);
endmodule

// File: rtl/regbank64_cfg.sv
module regbank64_cfg #(
  parameter int N_REGS   = 128,
  parameter int IDX_W    = 7,
  parameter int DW       = 64,
  parameter int CFG_BITS = 48,
  parameter int CMD_IDX  = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DW-1:0]              wdata,
  input  logic [IDX_W-1:0]           ridx,
  output logic [DW-1:0]              rd_word,
  output logic [N_REGS*CFG_BITS-1:0] cfg_flat,
  output logic                       cmd_pulse
);
  logic [N_REGS-1:0][CFG_BITS-1:0] regs;

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    if (g == CMD_IDX) begin : g_cmd
      assign regs[g] = '0;
    end else begin : g_store
      logic [CFG_BITS-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (we && widx == IDX_W'(g))
          q <= wdata[CFG_BITS-1:0];
      end
      assign regs[g] = q;
    end
    assign cfg_flat[g*CFG_BITS +: CFG_BITS] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cmd_pulse <= 1'b0;
    else
      cmd_pulse <= we && (widx == IDX_W'(CMD_IDX)) && wdata[0];
  end

  assign rd_word = DW'(regs[ridx]);
endmodule

// File: rtl/regbank64_stat.sv
module regbank64_stat #(
  parameter int          IDX_W       = 7,
  parameter int          DW          = 64,
  parameter int          N_STAT_IN   = 16,
  parameter int          CALIB_IDX   = 111,
  parameter int          STAMP_IDX   = 124,
  parameter int          ID_IDX      = 126,
  parameter logic [63:0] MODULE_ID   = 64'h0,
  parameter logic [63:0] BUILD_STAMP = 64'h0
) (
  input  logic [N_STAT_IN*DW-1:0] stat_flat,
  input  logic                    calib_done,
  input  logic [IDX_W-1:0]        ridx,
  output logic [DW-1:0]           rd_word
);
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < N_STAT_IN; k++)
      if (ridx == IDX_W'(k)) rd_word = stat_flat[k*DW +: DW];
    if (ridx == IDX_W'(CALIB_IDX))      rd_word = DW'(calib_done);
    else if (ridx == IDX_W'(STAMP_IDX)) rd_word = DW'(BUILD_STAMP);
    else if (ridx == IDX_W'(ID_IDX))    rd_word = DW'(MODULE_ID);
  end
endmodule

// File: rtl/regbank64.sv
module regbank64
  import regbank64_pkg::*;
#(
  parameter int          N_REGS      = 128,
  parameter int          DW          = 64,
  parameter int          CFG_BITS    = 48,
  parameter int          N_STAT_IN   = 16,
  parameter int          CMD_IDX     = DEF_CMD_IDX,
  parameter int          CALIB_IDX   = DEF_CALIB_IDX,
  parameter int          STAMP_IDX   = DEF_STAMP_IDX,
  parameter int          ID_IDX      = DEF_ID_IDX,
  parameter logic [63:0] MODULE_ID   = 64'h0000_5A17_0001_0003,
  parameter logic [63:0] BUILD_STAMP = 64'h0000_0000_2024_0612,
  localparam int         IDX_W       = $clog2(N_REGS),
  localparam int         ADDR_W      = IDX_W + 1,
  localparam int         STRB_W      = DW / 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DW-1:0]              wdata,
  input  logic [STRB_W-1:0]          wstrb,
  output logic [DW-1:0]              rdata,
  output logic                       rd_valid,
  input  logic [N_STAT_IN*DW-1:0]    stat_in,
  input  logic                       calib_done,
  output logic [N_REGS*CFG_BITS-1:0] cfg_q,
  output logic                       cmd_pulse
);
  space_e            space;
  logic [IDX_W-1:0]  idx;
  logic              wr_full;
  logic [DW-1:0]     cfg_word, stat_word;

  assign space = space_e'(addr[IDX_W]);
  assign idx   = addr[IDX_W-1:0];

  regbank64_wgate #(.STRB_W(STRB_W)) u_wgate (
    .wr_en(wr_en), .wstrb(wstrb), .space(space), .wr_full(wr_full)
  );

  regbank64_cfg #(
    .N_REGS(N_REGS), .IDX_W(IDX_W), .DW(DW),
    .CFG_BITS(CFG_BITS), .CMD_IDX(CMD_IDX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr_full), .widx(idx), .wdata(wdata),
    .ridx(idx), .rd_word(cfg_word), .cfg_flat(cfg_q), .cmd_pulse(cmd_pulse)
  );

  regbank64_stat #(
    .IDX_W(IDX_W), .DW(DW), .N_STAT_IN(N_STAT_IN),
    .CALIB_IDX(CALIB_IDX), .STAMP_IDX(STAMP_IDX), .ID_IDX(ID_IDX),
    .MODULE_ID(MODULE_ID), .BUILD_STAMP(BUILD_STAMP)
  ) u_stat (
    .stat_flat(stat_in), .calib_done(calib_done), .ridx(idx), .rd_word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rdata <= (space == SPACE_CONFIG) ? cfg_word : stat_word;
    end
  end
endmodule

// File: rtl/regbank64_chk.sv
module regbank64_chk #(
  parameter int          N_REGS      = 128,
  parameter int          DW          = 64,
  parameter int          CFG_BITS    = 48,
  parameter int          N_STAT_IN   = 16,
  parameter int          CMD_IDX     = 127,
  parameter int          CALIB_IDX   = 111,
  parameter int          ID_IDX      = 126,
  parameter logic [63:0] MODULE_ID   = 64'h0,
  localparam int         IDX_W       = $clog2(N_REGS),
  localparam int         ADDR_W      = IDX_W + 1,
  localparam int         STRB_W      = DW / 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [DW-1:0]           wdata,
  input logic [STRB_W-1:0]       wstrb,
  input logic [DW-1:0]           rdata,
  input logic                    rd_valid,
  input logic                    calib_done,
  input logic                    cmd_pulse
);
  localparam logic [ADDR_W-1:0] CMD_A   = {1'b1, IDX_W'(CMD_IDX)};
  localparam logic [ADDR_W-1:0] CALIB_A = {1'b0, IDX_W'(CALIB_IDX)};
  localparam logic [ADDR_W-1:0] ID_A    = {1'b0, IDX_W'(ID_IDX)};

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R2
  AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wstrb)) |=> !cmd_pulse); // R4
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_pulse) |-> $past(wr_en && addr == CMD_A && (&wstrb) && wdata[0])); // R6
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CMD_A) |=> rdata == '0); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[IDX_W]) |=> rdata[DW-1:CFG_BITS] == '0); // R5
  AST_CALIB_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CALIB_A) |=> rdata == DW'($past(calib_done))); // R7
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ID_A) |=> rdata == DW'(MODULE_ID)); // R8
endmodule

bind regbank64 regbank64_chk #(
  .N_REGS(N_REGS), .DW(DW), .CFG_BITS(CFG_BITS), .N_STAT_IN(N_STAT_IN),
  .CMD_IDX(CMD_IDX), .CALIB_IDX(CALIB_IDX), .ID_IDX(ID_IDX), .MODULE_ID(MODULE_ID)
) u_chk (.*);

// File: tb/regbank64_tb.sv
module regbank64_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 128;
  localparam int CB = 48;
  localparam int NS = 16;
  localparam logic [63:0] MID   = 64'h0000_5A17_0001_0003;
  localparam logic [63:0] STAMP = 64'h0000_0000_2024_0612;
  localparam logic [63:0] MASK  = (64'd1 << CB) - 64'd1;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, calib_done = 0;
  logic [7:0] addr = '0, wstrb = '0;
  logic [63:0] wdata = '0, rdata;
  logic rd_valid, cmd_pulse;
  logic [NS*64-1:0] stat_in;
  logic [NR*CB-1:0] cfg_q;
  int checks = 0, fails = 0;
  logic [63:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank64 #(.N_REGS(NR), .CFG_BITS(CB), .N_STAT_IN(NS),
              .MODULE_ID(MID), .BUILD_STAMP(STAMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .rd_valid(rd_valid),
    .stat_in(stat_in), .calib_done(calib_done), .cfg_q(cfg_q), .cmd_pulse(cmd_pulse));

  function automatic logic [63:0] spat(int k);
    return {32'hC0DE_0000 | 32'(k), ~(32'(k) * 32'h1111_1111)};
  endfunction
  function automatic logic [63:0] cpat(int k);
    return {32'hA5A5_0000 | 32'(k), 32'h1234_5678 ^ (32'(k) * 32'h0101_0101)};
  endfunction

  for (genvar k = 0; k < NS; k++) begin : g_st
    assign stat_in[k*64 +: 64] = spat(k);
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [7:0] s);
    addr = a; wdata = d; wstrb = s; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] v);
    addr = a; rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    chk(rd_valid, "R2 rd_valid", 64'(rd_valid), 64'd1);
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rdata == 0 && !rd_valid && !cmd_pulse, "R10 reset outputs", rdata, 0);
    chk(cfg_q == '0, "R10 cfg zero", cfg_q[63:0], 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_valid, "R2 idle valid", 64'(rd_valid), 0);

    // R3 R5 R11: fill every config register with upper bits set
    for (int i = 0; i < NR; i++) begin
      wr(8'(128 + i), cpat(i), 8'hFF);
      if (i != 127)
        chk(cfg_q[i*CB +: CB] == cpat(i)[CB-1:0], "R11 cfg_q slice",
            64'(cfg_q[i*CB +: CB]), cpat(i) & MASK);
    end
    for (int i = 0; i < NR; i++) begin
      rd(8'(128 + i), got);
      if (i == 127) chk(got == 0, "R6 cmd reads zero", got, 0);
      else chk(got == (cpat(i) & MASK), "R3 R5 cfg readback", got, cpat(i) & MASK);
    end

    // R9 R7 R8 status sweep
    calib_done = 0;
    for (int i = 0; i < NR; i++) begin
      logic [63:0] e;
      rd(8'(i), got);
      if (i == 111) e = 64'd0;
      else if (i == 124) e = STAMP;
      else if (i == 126) e = MID;
      else if (i < NS) e = spat(i);
      else e = 0;
      chk(got == e, "R9 R7 R8 status read", got, e);
    end
    calib_done = 1;
    rd(8'd111, got);
    chk(got == 64'd1, "R7 calib done", got, 1);

    // R1 write to status space has no effect
    wr(8'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    chk(!cmd_pulse, "R1 no pulse on status write", 64'(cmd_pulse), 0);
    rd(8'd3, got);
    chk(got == spat(3), "R1 status unchanged", got, spat(3));
    wr(8'd127, 64'd1, 8'hFF);
    chk(!cmd_pulse, "R1 status 127 write no pulse", 64'(cmd_pulse), 0);

    // R4 partial strobe sweep on stored register 5 and command register
    for (int s = 0; s < 255; s++) begin
      wr(8'd133, ~cpat(5) ^ 64'(s), 8'(s));
      rd(8'd133, got);
      chk(got == (cpat(5) & MASK), "R4 partial write dropped", got, cpat(5) & MASK);
    end
    for (int s = 0; s < 255; s++) begin
      wr(8'd255, 64'd1, 8'(s));
      chk(!cmd_pulse, "R4 partial cmd no pulse", 64'(cmd_pulse), 0);
    end

    // R6 command pulse
    wr(8'd255, 64'd1, 8'hFF);
    chk(cmd_pulse, "R6 pulse high", 64'(cmd_pulse), 1);
    @(negedge clk);
    chk(!cmd_pulse, "R6 pulse one cycle", 64'(cmd_pulse), 0);
    wr(8'd255, 64'd2, 8'hFF);
    chk(!cmd_pulse, "R6 bit0 clear no pulse", 64'(cmd_pulse), 0);
    rd(8'd255, got);
    chk(got == 0, "R6 cmd reads zero after write", got, 0);

    // R2 rdata holds when no read
    @(negedge clk);
    chk(!rd_valid && rdata == 0, "R2 hold idle", rdata, 0);

    // R10 reset clears config
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'd133, got);
    chk(got == 0, "R10 cfg cleared", got, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule